// File: doc/BRIEF.md
# Half-Rate Interpolate/Decimate Sequencer

This block sits in front of a half-band filter core and controls the sample rate around it. It registers a two's-complement input word and hands the filter a sample stream that always runs at the clock rate. It also tells the surrounding logic on which clocks the input port is taken and on which clocks the filter result is worth keeping. Two active-low select pins choose the mode:

- **Interpolate:** input is taken every other clock and zero samples are stuffed between the valid ones.
- **Decimate:** input is taken every clock and only every other result is marked valid.
- **Equal rate:** samples pass straight through at the clock rate.

One two-clock handshake on the sync pin fixes the phase. The pin is high on one clock and low on the next, and the clock on which it reads low is the one that carries the first input word. The same phase drives both the zero stuffing and the decimation strobe. After that the phase keeps alternating by itself. The sync pin may then stay low, or it may keep toggling at half rate in step with the phase. In equal-rate mode the sync pin is ignored. A build parameter chooses what "both selects low" means: equal rate, or interpolation with the valid samples doubled so that the stuffed stream keeps unity gain.

Top module: `halfband_rate_seq`

## Requirements
- R1: Mode decode. `interp_sel_n`=0 with `decim_sel_n`=1 selects interpolation at half gain. `decim_sel_n`=0 with `interp_sel_n`=1 selects decimation. Both high selects equal rate. Both low selects equal rate when `UNITY_BOTH_LOW`=0, and unity-gain interpolation when it is 1.
- R2: In half-gain interpolation, `in_take_o` is high only on aligned clocks. After an aligned clock, `smp_o` holds the sign-extended input. After any other clock it holds zero. `out_take_o` is high after every clock.
- R3: In unity-gain interpolation, `smp_o` after an aligned clock holds twice the input value (the input shifted left by one bit). After other clocks it holds zero, and `out_take_o` is high after every clock.
- R4: In decimation, `in_take_o` is high on every clock and `smp_o` follows the sign-extended input every clock. `out_take_o` is high only after aligned clocks.
- R5: In equal rate, `in_take_o` and `out_take_o` are always high and `smp_o` follows the sign-extended input with one clock of delay.
- R6: In any mode other than equal rate, a clock where `sync_in` is low and was high on the previous clock is an aligned clock. Aligned clocks then recur on every second clock.
- R7: When `sync_in` toggles at half rate in step with the current phase, the alternation continues without a missing or doubled aligned clock.
- R8: `smp_phase_o` is high exactly when the sample now in `smp_o` was registered on an aligned clock. This holds in every mode.
- R9: Synchronous reset clears `smp_o`, `in_take_o` is unaffected, `out_take_o` and `smp_phase_o` read 0, and the phase is cleared. The first clock after reset is not aligned and the second one is.
- R10: A sync handshake given in equal-rate mode leaves the phase untouched. The alternation carried into a later mode continues from where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| interp_sel_n | input | 1 | Interpolation select, active low |
| decim_sel_n | input | 1 | Decimation select, active low |
| sync_in | input | 1 | Phase handshake: high, then low on the first-word clock |
| din | input | IN_W | Two's-complement input sample |
| smp_o | output | IN_W+1 | Sample stream fed to the filter core |
| in_take_o | output | 1 | High on clocks where `din` is taken |
| out_take_o | output | 1 | High when the result for the current sample should be kept |
| smp_phase_o | output | 1 | Current sample came from an aligned clock |

## Verification
The hardest situation to reach is a sync handshake that lands against the phase the block is already running. Only this case exercises a realignment that changes the phase. It also has to be told apart from a harmless handshake that agrees with the current phase, and from one given in equal-rate mode that must be ignored. The stimulus walks every select-pin combination. In each one it places single handshakes at both parities, runs half-rate toggling in both phases, and then moves into another mode. This way the phase carried across mode changes is checked as well. Two instances built with different parameter values run side by side, so the two meanings of "both selects low" are compared on the same inputs.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  typedef enum logic [1:0] {
    RM_EQUAL    = 2'd0,
    RM_UP_HALF  = 2'd1,
    RM_UP_UNITY = 2'd2,
    RM_DOWN     = 2'd3
  } rate_mode_e;

  // Active-low selects; unity_low picks the meaning of both-low.
  function automatic rate_mode_e decode_rate(logic interp_n, logic decim_n, logic unity_low);
    rate_mode_e m;
    unique case ({interp_n, decim_n})
      2'b01:   m = RM_UP_HALF;
      2'b10:   m = RM_DOWN;
      2'b00:   m = unity_low ? RM_UP_UNITY : RM_EQUAL;
      default: m = RM_EQUAL;
    endcase
    return m;
  endfunction

  function automatic logic is_up(rate_mode_e m);
    return (m == RM_UP_HALF) || (m == RM_UP_UNITY);
  endfunction

endpackage

// File: rtl/hbr_mode_decode.sv
module hbr_mode_decode
  import hbr_pkg::*;
#(
  parameter bit UNITY_BOTH_LOW = 1'b0
) (
  input  logic       interp_sel_n,
  input  logic       decim_sel_n,
  output rate_mode_e mode
);

  always_comb mode = decode_rate(interp_sel_n, decim_sel_n, UNITY_BOTH_LOW);

endmodule

// File: rtl/hbr_phase_track.sv
module hbr_phase_track
  import hbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_in,
  input  rate_mode_e mode,
  output logic       aligned,
  output logic       sync_fall
);

  logic sync_q;
  logic ph_q;

  // A high-then-low handshake marks the current clock; ignored at equal rate.
  always_comb begin
    sync_fall = sync_q & ~sync_in & (mode != RM_EQUAL);
    aligned   = sync_fall | ph_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      ph_q   <= 1'b0;
    end else begin
      sync_q <= sync_in;
      ph_q   <= ~aligned;
    end
  end

endmodule

// File: rtl/hbr_sample_path.sv
module hbr_sample_path
  import hbr_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = IN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  rate_mode_e       mode,
  input  logic             aligned,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] smp_o,
  output logic             in_take_o,
  output logic             out_take_o,
  output logic             smp_phase_o
);

  function automatic logic [OUT_W-1:0] widen(logic [IN_W-1:0] x);
    return OUT_W'($signed(x));
  endfunction

  function automatic logic [OUT_W-1:0] doubled(logic [IN_W-1:0] x);
    return OUT_W'($signed({x, 1'b0}));
  endfunction

  logic [OUT_W-1:0] smp_d;

  always_comb begin
    in_take_o = is_up(mode) ? aligned : 1'b1;
    unique case (mode)
      RM_UP_HALF:  smp_d = aligned ? widen(din)   : '0;
      RM_UP_UNITY: smp_d = aligned ? doubled(din) : '0;
      default:     smp_d = widen(din);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_o       <= '0;
      out_take_o  <= 1'b0;
      smp_phase_o <= 1'b0;
    end else begin
      smp_o       <= smp_d;
      out_take_o  <= (mode == RM_DOWN) ? aligned : 1'b1;
      smp_phase_o <= aligned;
    end
  end

endmodule

// File: rtl/halfband_rate_seq.sv
module halfband_rate_seq
  import hbr_pkg::*;
#(
  parameter int  IN_W           = 12,
  parameter bit  UNITY_BOTH_LOW = 1'b0,
  localparam int OUT_W          = IN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             interp_sel_n,
  input  logic             decim_sel_n,
  input  logic             sync_in,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] smp_o,
  output logic             in_take_o,
  output logic             out_take_o,
  output logic             smp_phase_o
);

  rate_mode_e mode_w;
  logic       aligned_w;
  logic       sync_fall_w;

  hbr_mode_decode #(.UNITY_BOTH_LOW(UNITY_BOTH_LOW)) u_mode (
    .interp_sel_n(interp_sel_n),
    .decim_sel_n (decim_sel_n),
    .mode        (mode_w)
  );

  hbr_phase_track u_phase (
    .clk      (clk),
    .rst      (rst),
    .sync_in  (sync_in),
    .mode     (mode_w),
    .aligned  (aligned_w),
    .sync_fall(sync_fall_w)
  );

  hbr_sample_path #(.IN_W(IN_W), .OUT_W(OUT_W)) u_path (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode_w),
    .aligned    (aligned_w),
    .din        (din),
    .smp_o      (smp_o),
    .in_take_o  (in_take_o),
    .out_take_o (out_take_o),
    .smp_phase_o(smp_phase_o)
  );

endmodule

// File: rtl/hbr_seq_chk.sv
module hbr_seq_chk
  import hbr_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = IN_W + 1
) (
  input logic             clk,
  input logic             rst,
  input rate_mode_e       mode,
  input logic             aligned,
  input logic             sync_fall,
  input logic [IN_W-1:0]  din,
  input logic [OUT_W-1:0] smp,
  input logic             in_take,
  input logic             out_take,
  input logic             smp_phase
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_down_takes_all_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == RM_DOWN) |-> in_take);

  assert_down_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == RM_DOWN) |=> (out_take == $past(aligned)));

  assert_equal_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == RM_EQUAL) |=> (out_take && ($signed(smp) == $signed($past(din)))));

  assert_zero_stuff_R2: assert property (@(posedge clk) disable iff (rst)
    (is_up(mode) && !aligned) |=> (smp == '0));

  assert_unity_gain_R3: assert property (@(posedge clk) disable iff (rst)
    ((mode == RM_UP_UNITY) && aligned) |=> ($signed(smp) == 2 * $signed($past(din))));

  assert_gap_then_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !aligned) |=> aligned);

  assert_no_double_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && aligned) |=> (!aligned || sync_fall));

  assert_phase_flag_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (smp_phase == $past(aligned)));

  assert_equal_ignores_sync_R10: assert property (@(posedge clk) disable iff (rst)
    (mode == RM_EQUAL) |-> !sync_fall);

endmodule

bind halfband_rate_seq hbr_seq_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode_w),
  .aligned  (aligned_w),
  .sync_fall(sync_fall_w),
  .din      (din),
  .smp      (smp_o),
  .in_take  (in_take_o),
  .out_take (out_take_o),
  .smp_phase(smp_phase_o)
);

// File: tb/tb_halfband_rate_seq.sv
`timescale 1ns/1ps
module tb_halfband_rate_seq;

  localparam int IN_W = 12;
  localparam int OUT_W = IN_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic interp_sel_n = 1'b1;
  logic decim_sel_n = 1'b1;
  logic sync_in = 1'b0;
  logic [IN_W-1:0] din = '0;

  logic [OUT_W-1:0] smp [2];
  logic in_take [2];
  logic out_take [2];
  logic phase [2];

  always #10 clk = ~clk;

  halfband_rate_seq #(.IN_W(IN_W), .UNITY_BOTH_LOW(1'b0)) dut (
    .clk(clk), .rst(rst), .interp_sel_n(interp_sel_n), .decim_sel_n(decim_sel_n),
    .sync_in(sync_in), .din(din), .smp_o(smp[0]), .in_take_o(in_take[0]),
    .out_take_o(out_take[0]), .smp_phase_o(phase[0]));

  halfband_rate_seq #(.IN_W(IN_W), .UNITY_BOTH_LOW(1'b1)) dut_u (
    .clk(clk), .rst(rst), .interp_sel_n(interp_sel_n), .decim_sel_n(decim_sel_n),
    .sync_in(sync_in), .din(din), .smp_o(smp[1]), .in_take_o(in_take[1]),
    .out_take_o(out_take[1]), .smp_phase_o(phase[1]));

  int n_chk = 0;
  int n_fail = 0;
  int k;
  int anc [2];
  bit prev_s;
  int lcg = 12345;
  bit done = 1'b0;

  task automatic chk(input string req, input int x, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s inst=%0d actual=%0d expected=%0d", req, x, act, exp);
    end
  endtask

  task automatic model_reset();
    k = 0;
    anc[0] = 1;
    anc[1] = 1;
    prev_s = 1'b0;
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic step(input int v, input bit s, input bit in_n, input bit dn_n, input string tag);
    int exp_smp [2];
    bit exp_in [2];
    bit exp_out [2];
    bit exp_al [2];
    string mtag [2];
    bit fall;
    din = IN_W'(v);
    sync_in = s;
    interp_sel_n = in_n;
    decim_sel_n = dn_n;
    fall = prev_s && !s;
    for (int x = 0; x < 2; x++) begin
      bit both_low, eq, up, unity, down;
      both_low = !in_n && !dn_n;
      eq    = (in_n && dn_n) || (both_low && x == 0);
      unity = both_low && x == 1;
      up    = (!in_n && dn_n) || unity;
      down  = in_n && !dn_n;
      if (fall && !eq) anc[x] = k;
      exp_al[x] = ((k ^ anc[x]) & 1) == 0;
      exp_in[x] = up ? exp_al[x] : 1'b1;
      exp_smp[x] = up ? (exp_al[x] ? (unity ? 2 * v : v) : 0) : v;
      exp_out[x] = down ? exp_al[x] : 1'b1;
      mtag[x] = up ? (unity ? "R3" : "R2") : (down ? "R4" : "R5");
      if (both_low) mtag[x] = {mtag[x], " R1"};
    end
    #1;
    for (int x = 0; x < 2; x++) chk({mtag[x], " in_take"}, x, int'(in_take[x]), int'(exp_in[x]));
    @(negedge clk);
    for (int x = 0; x < 2; x++) begin
      chk({mtag[x], " smp"}, x, int'($signed(smp[x])), exp_smp[x]);
      chk({mtag[x], " out_take"}, x, int'(out_take[x]), int'(exp_out[x]));
      chk({"R8 phase ", tag}, x, int'(phase[x]), int'(exp_al[x]));
    end
    prev_s = s;
    k++;
  endtask

  function automatic int next_val();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return ((lcg >> 8) & 12'hfff) - 2048;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sync_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int x = 0; x < 2; x++) begin
      chk("R9 reset smp", x, int'(smp[x]), 0);
      chk("R9 reset out_take", x, int'(out_take[x]), 0);
      chk("R9 reset phase", x, int'(phase[x]), 0);
    end
    rst = 1'b0;
    sync_in = 1'b0;
    model_reset();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: free-running phase right after reset, interpolate mode
    for (int i = 0; i < 4; i++) step(next_val(), 1'b0, 1'b0, 1'b1, "R9");
    for (int pc = 0; pc < 4; pc++) begin
      bit in_n, dn_n;
      string st;
      in_n = pc[1];
      dn_n = pc[0];
      st = (in_n && dn_n) ? "R10" : "R6";
      for (int i = 0; i < 5; i++) step(next_val(), 1'b0, in_n, dn_n, st);
      // single handshakes landing at both parities
      for (int off = 0; off < 2; off++) begin
        for (int i = 0; i < off; i++) step(next_val(), 1'b0, in_n, dn_n, st);
        step(next_val(), 1'b1, in_n, dn_n, st);
        for (int i = 0; i < 5; i++) step(next_val(), 1'b0, in_n, dn_n, st);
      end
      // half-rate toggling in both phases
      for (int ph = 0; ph < 2; ph++) begin
        for (int i = 0; i < 12; i++) step(next_val(), bit'((i + ph) & 1), in_n, dn_n, "R7");
        step(next_val(), 1'b0, in_n, dn_n, "R7");
      end
      step(-2048, 1'b0, in_n, dn_n, "R6");
      step(2047, 1'b0, in_n, dn_n, "R6");
      step(-1, 1'b0, in_n, dn_n, "R6");
      step(0, 1'b0, in_n, dn_n, "R6");
      step(1, 1'b0, in_n, dn_n, "R6");
    end
    // R10: handshake at equal rate, then continue in interpolation
    for (int i = 0; i < 3; i++) step(next_val(), 1'b0, 1'b1, 1'b1, "R10");
    step(next_val(), 1'b1, 1'b1, 1'b1, "R10");
    step(next_val(), 1'b0, 1'b1, 1'b1, "R10");
    for (int i = 0; i < 6; i++) step(next_val(), 1'b0, 1'b0, 1'b1, "R10");
    // R9: reset again in decimate mode
    do_reset();
    for (int i = 0; i < 6; i++) step(next_val(), 1'b0, 1'b1, 1'b0, "R9");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule